// File: doc/BRIEF.md
# Reduction Write-Back Merge Engine

This engine sits beside the home memory of a shared-memory node and folds partial reduction results into the shared copy of a line. Each accepted write-back carries a full line of `WORDS` elements. The engine reads the current line from memory, combines every element pair with the configured operator, and writes the merged line back. A zero element in the incoming line leaves the matching memory element unchanged, because zero is the identity for both supported operators: wrapping addition and unsigned maximum.

Before the first merge of a line, the engine cleans up plain (non-reduction) copies that still sit in caches. It first checks the sharer status for the line. A dirty copy is recalled and written to memory. All sharers are then invalidated, and the directory entry is cleared. Later write-backs to the same line find no sharers and go straight to the merge. Elements pass through a two-stage arithmetic pipeline, one per cycle, in ascending word order. The input port stays closed for the whole of a transaction, so a second write-back to the same line waits until the first one's memory write has completed.

Top module: `rdx_home_merge`

## Requirements
- R1: Each accepted write-back causes exactly one memory read of its line, followed by exactly one write of the merged line to the same address. The read uses `memReq` with `memWe`=0, and the write uses `memReq` with `memWe`=1. Every request is held until `memAck` arrives.
- R2: With `cfgMax`=0, memory element k (bits k*EW+EW-1 down to k*EW) becomes (old + new) modulo 2^EW.
- R3: With `cfgMax`=1, memory element k becomes the unsigned maximum of old and new.
- R4: An incoming element equal to zero leaves the stored element unchanged, under either operator.
- R5: If the lookup reports a dirty copy (`lkDirty`=1), a recall is issued first. The recalled line is written to memory, and the merge reads and combines that recalled data, never the stale memory line.
- R6: If the sharer vector is non-zero, one invalidation is sent with `invMask` equal to that vector, and `dirClear` pulses once. A later write-back whose sharer vector is zero sends no invalidation.
- R7: Elements enter the two-cycle pipeline one per cycle in ascending word order. The merged line is written only after all `WORDS` results have returned.
- R8: `wbReady` is 0 from acceptance until the final memory write is acknowledged, including the whole time a recall or an invalidation is outstanding.
- R9: After reset, `wbReady`=1, and `memReq`, `recallReq`, `invReq` and `dirClear` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMax | input | 1 | Operator select, sampled with the write-back: 0 add, 1 unsigned max |
| wbValid | input | 1 | Incoming write-back present |
| wbReady | output | 1 | Engine can accept a write-back |
| wbAddr | input | AW | Line address of the write-back |
| wbLine | input | EW*WORDS | Partial results, element k at bits k*EW upward |
| tgtAddr | output | AW | Line under service, for status lookup, recall and invalidate |
| lkSharers | input | NSHR | Plain sharer vector for `tgtAddr` |
| lkDirty | input | 1 | One sharer holds `tgtAddr` dirty |
| recallReq | output | 1 | Recall the dirty copy of `tgtAddr` |
| recallAck | input | 1 | Recall complete, `recallLine` valid |
| recallLine | input | EW*WORDS | Recalled line data |
| invReq | output | 1 | Invalidate the sharers in `invMask` |
| invMask | output | NSHR | Sharers to invalidate |
| invAck | input | 1 | All invalidations acknowledged |
| dirClear | output | 1 | One-cycle pulse: clear the sharer/dirty status of `tgtAddr` |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | AW | Memory line address |
| memWdata | output | EW*WORDS | Write data |
| memAck | input | 1 | Access complete, `memRdata` valid on reads |
| memRdata | input | EW*WORDS | Read data |

## Verification
The bench targets word 7. In the table vectors it carries a zero while the other words carry live data, so a design that combined with a wrong identity, or stopped short of the last element, would corrupt that one word. Addition vectors include a wrap past 2^32, and maximum vectors include operands with the top bit set; a signed comparator or a carry-out leak would show up there. A directed case fills every word with a distinct value, so a pipeline that shuffled result slots, or wrote the line before the last result returned, would leave a mismatched word. The cleanup cases plant a stale memory line under a dirty copy, so a design that read memory before the recall would merge the stale data. A repeat write-back to the same line then confirms that no second invalidation goes out.

// File: rtl/rdx_merge_pkg.sv
package rdx_merge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_RECALL, ST_RWR, ST_INV, ST_RD, ST_COMB, ST_WR
  } mergeState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic captureWb;
    logic captureRecall;
    logic captureRd;
    logic feed;
    logic selRecall;
  } mergeStb_t;

endpackage

// File: rtl/rdx_elem_alu.sv
module rdx_elem_alu #(
  parameter int EW = 32
) (
  input  logic          useMax,
  input  logic [EW-1:0] oldVal,
  input  logic [EW-1:0] newVal,
  output logic [EW-1:0] res
);
  always_comb begin
    if (useMax) res = (newVal > oldVal) ? newVal : oldVal;
    else        res = oldVal + newVal;
  end
endmodule

// File: rtl/rdx_merge_dp.sv
module rdx_merge_dp
  import rdx_merge_pkg::*;
#(
  parameter int AW    = 16,
  parameter int EW    = 32,
  parameter int WORDS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  mergeStb_t           stb,
  input  logic                wbMax,
  input  logic [AW-1:0]       wbAddr,
  input  logic [EW*WORDS-1:0] wbLine,
  input  logic [EW*WORDS-1:0] memRdata,
  input  logic [EW*WORDS-1:0] recallLine,
  output logic [AW-1:0]       tgtAddr,
  output logic [EW*WORDS-1:0] memWdata,
  output logic                feedDone,
  output logic                allDone
);
  localparam int LW = EW * WORDS;
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CW = IW + 1;

  logic [AW-1:0] addrR;
  logic [LW-1:0] newLine, oldLine, resFlat;
  logic          maxR;
  logic [CW-1:0] feedIdx, resCnt;
  logic [EW-1:0] oldW [WORDS];
  logic [EW-1:0] newW [WORDS];
  logic [EW-1:0] resW [WORDS];

  // pipeline stage registers
  logic          aVal, bVal;
  logic [EW-1:0] aOld, aNew, aluY, bRes;
  logic [IW-1:0] aIdx, bIdx;

  for (genvar k = 0; k < WORDS; k++) begin : g_words
    assign oldW[k] = oldLine[k*EW +: EW];
    assign newW[k] = newLine[k*EW +: EW];
    assign resFlat[k*EW +: EW] = resW[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR   <= '0;
      maxR    <= 1'b0;
      feedIdx <= '0;
      resCnt  <= '0;
      aVal    <= 1'b0;
      bVal    <= 1'b0;
    end else begin
      if (stb.captureWb) begin
        addrR <= wbAddr;
        maxR  <= wbMax;
      end
      aVal <= stb.feed;
      bVal <= aVal;
      if (stb.captureRd) begin
        feedIdx <= '0;
        resCnt  <= '0;
      end else begin
        if (stb.feed) feedIdx <= feedIdx + 1'b1;
        if (bVal)     resCnt  <= resCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.captureWb)     newLine <= wbLine;
    if (stb.captureRecall) oldLine <= recallLine;
    else if (stb.captureRd) oldLine <= memRdata;
    if (stb.feed) begin
      aOld <= oldW[feedIdx[IW-1:0]];
      aNew <= newW[feedIdx[IW-1:0]];
      aIdx <= feedIdx[IW-1:0];
    end
    bRes <= aluY;
    bIdx <= aIdx;
    if (bVal) resW[bIdx] <= bRes;
  end

  rdx_elem_alu #(.EW(EW)) u_alu (
    .useMax (maxR),
    .oldVal (aOld),
    .newVal (aNew),
    .res    (aluY)
  );

  assign tgtAddr  = addrR;
  assign memWdata = stb.selRecall ? oldLine : resFlat;
  assign feedDone = (feedIdx == CW'(WORDS));
  assign allDone  = (resCnt == CW'(WORDS));

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    aVal |=> bVal) else $error("result not two cycles after issue"); // R7
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (bVal && bIdx != '0) |-> ($past(bVal) && ($past(bIdx) + 1'b1) == bIdx))
    else $error("elements out of ascending order"); // R7
endmodule

// File: rtl/rdx_merge_ctl.sv
module rdx_merge_ctl
  import rdx_merge_pkg::*;
#(
  parameter int NSHR = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wbValid,
  input  logic [NSHR-1:0] lkSharers,
  input  logic            lkDirty,
  input  logic            memAck,
  input  logic            recallAck,
  input  logic            invAck,
  input  logic            feedDone,
  input  logic            allDone,
  output logic            wbReady,
  output logic            memReq,
  output logic            memWe,
  output logic            recallReq,
  output logic            invReq,
  output logic [NSHR-1:0] invMask,
  output logic            dirClear,
  output mergeStb_t       stb
);
  mergeState_t state, nxt;
  logic [NSHR-1:0] shrR;
  logic pendClean;

  always_comb begin
    nxt       = state;
    stb       = '0;
    wbReady   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    recallReq = 1'b0;
    invReq    = 1'b0;
    dirClear  = 1'b0;
    case (state)
      ST_IDLE: begin
        wbReady = 1'b1;
        if (wbValid) begin
          stb.captureWb = 1'b1;
          nxt = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (lkDirty)         nxt = ST_RECALL;
        else if (|lkSharers) nxt = ST_INV;
        else                 nxt = ST_RD;
      end
      ST_RECALL: begin
        recallReq = 1'b1;
        if (recallAck) begin
          stb.captureRecall = 1'b1;
          nxt = ST_RWR;
        end
      end
      ST_RWR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        stb.selRecall = 1'b1;
        if (memAck) begin
          if (|shrR) nxt = ST_INV;
          else begin
            dirClear = 1'b1;
            nxt = ST_RD;
          end
        end
      end
      ST_INV: begin
        invReq = 1'b1;
        if (invAck) begin
          dirClear = 1'b1;
          nxt = ST_RD;
        end
      end
      ST_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.captureRd = 1'b1;
          nxt = ST_COMB;
        end
      end
      ST_COMB: begin
        stb.feed = !feedDone;
        if (allDone) nxt = ST_WR;
      end
      ST_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      shrR      <= '0;
      pendClean <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_LOOK) begin
        shrR      <= lkSharers;
        pendClean <= lkDirty || (|lkSharers);
      end else if (dirClear) begin
        pendClean <= 1'b0;
      end
    end
  end

  assign invMask = shrR;

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    wbReady |-> (!recallReq && !invReq && !memReq)) else $error("port open while busy"); // R8
  AST_CLEAN_BEFORE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> !pendClean) else $error("merge read before cleanup"); // R5
  AST_WRITE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR) |-> allDone) else $error("write before all results"); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe))) else $error("request dropped"); // R1
endmodule

// File: rtl/rdx_home_merge.sv
module rdx_home_merge
  import rdx_merge_pkg::*;
#(
  parameter int AW    = 16,
  parameter int EW    = 32,
  parameter int WORDS = 8,
  parameter int NSHR  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgMax,
  input  logic                wbValid,
  output logic                wbReady,
  input  logic [AW-1:0]       wbAddr,
  input  logic [EW*WORDS-1:0] wbLine,
  output logic [AW-1:0]       tgtAddr,
  input  logic [NSHR-1:0]     lkSharers,
  input  logic                lkDirty,
  output logic                recallReq,
  input  logic                recallAck,
  input  logic [EW*WORDS-1:0] recallLine,
  output logic                invReq,
  output logic [NSHR-1:0]     invMask,
  input  logic                invAck,
  output logic                dirClear,
  output logic                memReq,
  output logic                memWe,
  output logic [AW-1:0]       memAddr,
  output logic [EW*WORDS-1:0] memWdata,
  input  logic                memAck,
  input  logic [EW*WORDS-1:0] memRdata
);
  mergeStb_t stb;
  logic feedDone, allDone;

  rdx_merge_ctl #(.NSHR(NSHR)) u_ctl (
    .clk, .rstN, .wbValid, .lkSharers, .lkDirty, .memAck, .recallAck, .invAck,
    .feedDone, .allDone, .wbReady, .memReq, .memWe, .recallReq, .invReq,
    .invMask, .dirClear, .stb
  );

  rdx_merge_dp #(.AW(AW), .EW(EW), .WORDS(WORDS)) u_dp (
    .clk, .rstN, .stb, .wbMax(cfgMax), .wbAddr, .wbLine, .memRdata, .recallLine,
    .tgtAddr, .memWdata, .feedDone, .allDone
  );

  assign memAddr = tgtAddr;
endmodule

// File: tb/sim_rdx_home_merge.sv
module sim_rdx_home_merge;
  localparam int AW = 16, EW = 32, WORDS = 8, NSHR = 4;
  localparam int LW = EW * WORDS;

  logic clk = 0, rstN = 0;
  logic cfgMax = 0, wbValid = 0, wbReady;
  logic [AW-1:0] wbAddr = '0, tgtAddr, memAddr;
  logic [LW-1:0] wbLine = '0, recallLine = '0, memWdata, memRdata = '0;
  logic [NSHR-1:0] lkSharers, invMask;
  logic lkDirty, recallReq, recallAck = 0, invReq, invAck = 0, dirClear;
  logic memReq, memWe, memAck = 0;

  logic [LW-1:0]   mem [16];
  logic [LW-1:0]   dtyLine [16];
  logic [NSHR-1:0] shrTab [16];
  logic            dtyTab [16];
  int memWrCnt = 0, memRdCnt = 0, recallCnt = 0, invCnt = 0;
  logic [NSHR-1:0] lastMask = '0;
  logic bpViol = 0, timedOut = 0;
  int cyc = 0, nChk = 0, nErr = 0;

  // vector: {op, old, new, expected}; word 7 of the incoming line is zero
  localparam logic [96:0] VEC [6] = '{
    {1'b0, 32'd5,          32'd7,          32'd12},
    {1'b0, 32'hFFFF_FFFF,  32'd2,          32'd1},
    {1'b0, 32'h1234_0000,  32'h0000_5678,  32'h1234_5678},
    {1'b1, 32'd10,         32'd3,          32'd10},
    {1'b1, 32'd3,          32'd10,         32'd10},
    {1'b1, 32'h8000_0000,  32'h7FFF_FFFF,  32'h8000_0000}
  };

  rdx_home_merge #(.AW(AW), .EW(EW), .WORDS(WORDS), .NSHR(NSHR)) u0 (
    .clk, .rstN, .cfgMax, .wbValid, .wbReady, .wbAddr, .wbLine, .tgtAddr,
    .lkSharers, .lkDirty, .recallReq, .recallAck, .recallLine, .invReq, .invMask,
    .invAck, .dirClear, .memReq, .memWe, .memAddr, .memWdata, .memAck, .memRdata
  );

  always #5 clk = ~clk;

  assign lkSharers = shrTab[tgtAddr[3:0]];
  assign lkDirty   = dtyTab[tgtAddr[3:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) timedOut <= 1'b1;
    if (dirClear) begin
      shrTab[tgtAddr[3:0]] <= '0;
      dtyTab[tgtAddr[3:0]] <= 1'b0;
    end
  end

  // responders: answer a request one cycle after it appears
  always @(negedge clk) begin
    if (rstN && memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin mem[memAddr[3:0]] <= memWdata; memWrCnt <= memWrCnt + 1; end
      else begin memRdata <= mem[memAddr[3:0]]; memRdCnt <= memRdCnt + 1; end
    end else memAck <= 1'b0;
    if (rstN && recallReq && !recallAck) begin
      recallAck <= 1'b1; recallLine <= dtyLine[tgtAddr[3:0]]; recallCnt <= recallCnt + 1;
    end else recallAck <= 1'b0;
    if (rstN && invReq && !invAck) begin
      invAck <= 1'b1; lastMask <= invMask; invCnt <= invCnt + 1;
    end else invAck <= 1'b0;
    if ((recallReq || invReq) && wbReady) bpViol <= 1'b1;
  end

  function automatic logic [EW-1:0] combE(input logic [EW-1:0] o, input logic [EW-1:0] n, input bit mx);
    if (mx) return (n > o) ? n : o;
    return o + n;
  endfunction

  function automatic logic [LW-1:0] combL(input logic [LW-1:0] o, input logic [LW-1:0] n, input bit mx);
    logic [LW-1:0] r;
    for (int k = 0; k < WORDS; k++) r[k*EW +: EW] = combE(o[k*EW +: EW], n[k*EW +: EW], mx);
    return r;
  endfunction

  function automatic logic [LW-1:0] fill(input logic [EW-1:0] v, input logic [EW-1:0] last);
    logic [LW-1:0] r;
    for (int k = 0; k < WORDS; k++) r[k*EW +: EW] = (k == WORDS-1) ? last : v;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int wrAtDone;
  task automatic runWb(input logic [3:0] a, input logic [LW-1:0] ln, input bit mx);
    @(negedge clk);
    wbAddr = {{(AW-4){1'b0}}, a}; wbLine = ln; cfgMax = mx; wbValid = 1'b1;
    @(negedge clk);
    wbValid = 1'b0;
    while (!wbReady && !timedOut) @(negedge clk);
    wrAtDone = memWrCnt;
  endtask

  initial begin
    int wr0, rd0, rc0, iv0;
    logic [LW-1:0] oldL, newL, expL;
    for (int i = 0; i < 16; i++) begin
      mem[i] = '0; dtyLine[i] = '0; shrTab[i] = '0; dtyTab[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(wbReady === 1'b1, "R9 ready", LW'(wbReady), LW'(1));
    chk({memReq, recallReq, invReq, dirClear} === 4'b0, "R9 idle outputs",
        LW'({memReq, recallReq, invReq, dirClear}), '0);
    rstN = 1'b1;
    @(negedge clk);

    // table of vectors on line 2
    for (int v = 0; v < 6; v++) begin
      mem[2] = fill(VEC[v][95:64], VEC[v][95:64]);
      runWb(4'd2, fill(VEC[v][63:32], '0), VEC[v][96]);
      expL = fill(VEC[v][31:0], VEC[v][95:64]);
      chk(mem[2][LW-EW-1:0] === expL[LW-EW-1:0], VEC[v][96] ? "R3 max words" : "R2 add words",
          mem[2], expL);
      chk(mem[2][LW-1 -: EW] === VEC[v][95:64], "R4 zero word unchanged", mem[2], expL);
    end

    // R2 R7: distinct per-word values, one read and one write (R1)
    for (int k = 0; k < WORDS; k++) begin
      oldL[k*EW +: EW] = 32'(100 * k + 1);
      newL[k*EW +: EW] = 32'(k + 3);
    end
    mem[3] = oldL;
    wr0 = memWrCnt; rd0 = memRdCnt;
    runWb(4'd3, newL, 1'b0);
    expL = combL(oldL, newL, 1'b0);
    chk(mem[3] === expL, "R7 per-word order", mem[3], expL);
    chk(memRdCnt - rd0 == 1, "R1 read count", LW'(memRdCnt - rd0), LW'(1));
    chk(memWrCnt - wr0 == 1, "R1 write count", LW'(memWrCnt - wr0), LW'(1));

    // R5 R6 R8: dirty copy plus sharer on line 5, stale memory
    mem[5] = fill(32'hDEAD_0000, 32'hDEAD_0000);
    dtyLine[5] = fill(32'd40, 32'd41);
    shrTab[5] = 4'b0100; dtyTab[5] = 1'b1;
    wr0 = memWrCnt; rc0 = recallCnt; iv0 = invCnt; bpViol = 1'b0;
    newL = fill(32'd2, 32'd0);
    runWb(4'd5, newL, 1'b0);
    expL = combL(dtyLine[5], newL, 1'b0);
    chk(recallCnt - rc0 == 1, "R5 recall issued", LW'(recallCnt - rc0), LW'(1));
    chk(mem[5] === expL, "R5 merge uses recalled line", mem[5], expL);
    chk(invCnt - iv0 == 1 && lastMask == 4'b0100, "R6 invalidate mask",
        LW'(lastMask), LW'(4'b0100));
    chk(wrAtDone - wr0 == 2, "R8 ready after final write", LW'(wrAtDone - wr0), LW'(2));
    chk(bpViol == 1'b0, "R8 back-pressure during cleanup", LW'(bpViol), '0);

    // R6: sharers only on line 6, then a repeat with empty list
    mem[6] = fill(32'd7, 32'd7);
    shrTab[6] = 4'b1011;
    rc0 = recallCnt; iv0 = invCnt;
    runWb(4'd6, fill(32'd1, 32'd1), 1'b0);
    chk(invCnt - iv0 == 1 && lastMask == 4'b1011, "R6 sharer invalidate",
        LW'(lastMask), LW'(4'b1011));
    chk(recallCnt == rc0, "R5 no recall when clean", LW'(recallCnt - rc0), '0);
    iv0 = invCnt;
    runWb(4'd6, fill(32'd1, 32'd1), 1'b0);
    chk(invCnt == iv0, "R6 no second invalidate", LW'(invCnt - iv0), '0);
    chk(mem[6] === fill(32'd9, 32'd9), "R2 repeated accumulation", mem[6], fill(32'd9, 32'd9));

    // R4: all-zero line in max mode
    mem[7] = fill(32'h0BAD_F00D, 32'h1);
    runWb(4'd7, '0, 1'b1);
    chk(mem[7] === fill(32'h0BAD_F00D, 32'h1), "R4 neutral line", mem[7], fill(32'h0BAD_F00D, 32'h1));

    if (timedOut) begin
      nChk++; nErr++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule